// File: doc/BRIEF.md
# Serial Configuration Loader for a Display Driver

This block is the serial loading front end of a display driver. It holds three shift-register and holding-latch pairs: a long gray-scale data register, an 8-bit brightness register and an 8-bit monitor register. A 2-bit select picks which pair takes serial data. Bits enter on the serial data input and advance one place on every rising edge of the serial clock, but only while the active-low shift enable is asserted. The most significant bit of the selected shift register appears on the serial output so that several devices can be cascaded.

A level-sensitive latch enable copies the selected shift register into its holding latch for as long as it stays high. Two active-low strap inputs force the brightness and monitor latches to fixed defaults. The brightness latch cannot be rewritten while the driver outputs are on. Only the latched fields are exported; the PWM engine, the current DACs and the comparators sit outside this block. All inputs are synchronous to `clk`. The serial clock is sampled in that domain and acts on its rising edge.

Top module: `sdrv_serial_cfg`

## Requirements
- R1: On a rising serial-clock edge with `shift_en_n` low, only the shift register named by `reg_sel` advances one place toward its MSB and takes `sin` into bit 0. The encoding is 00 gray-scale, 01 brightness, 10 monitor.
- R2: With `shift_en_n` high, or with no rising serial-clock edge, no shift register changes.
- R3: The gray-scale register is 64 bits long when `gs_wide` is 0 and 128 bits when it is 1. The serial output taps bit 63 or bit 127 to match.
- R4: `sout` is the MSB of the selected shift register and changes in the same `clk` cycle as the shift. With `reg_sel` = 11, `sout` is 0.
- R5: While `latch_en` is high, the selected latch follows its shift register one `clk` cycle later. While `latch_en` is low, the latch holds.
- R6: Select code 11 shifts nothing and loads no latch.
- R7: Brightness latch bits [7:5] drive `bc_div` and bits [4:0] drive `bc_cur`.
- R8: While `bc_cfg_en` is low, the brightness latch is forced to `bc_div`=000, `bc_cur`=11111. This holds whatever `outputs_off` is.
- R9: While `mon_cfg_en` is low, `mon_cfg` is forced to 0x01. A loaded monitor value keeps only shift bits [3:0], and `mon_cfg[7:4]` always reads 0.
- R10: While `outputs_off` is low, the brightness latch does not change through `latch_en`. The other latches still load.
- R11: Reset clears all shift registers and `gs_data`, sets the brightness latch to 000/11111 and sets `mon_cfg` to 0x01.
- R12: A gray-scale latch loaded with `gs_wide` = 0 holds shift bits [63:0] in `gs_data[63:0]`, with `gs_data[127:64]` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | synchronous active-low reset |
| sclk | input | 1 | serial clock, acts on its rising edge |
| sin | input | 1 | serial data in |
| shift_en_n | input | 1 | active-low shift enable |
| reg_sel | input | 2 | target pair: 00 gray, 01 brightness, 10 monitor, 11 none |
| gs_wide | input | 1 | 1 = 128-bit gray register, 0 = 64-bit |
| latch_en | input | 1 | level-sensitive latch enable |
| bc_cfg_en | input | 1 | low forces brightness defaults |
| mon_cfg_en | input | 1 | low forces monitor default |
| outputs_off | input | 1 | 1 = outputs blanked; 0 locks the brightness latch |
| sout | output | 1 | serial cascade output |
| gs_data | output | 128 | latched gray-scale data |
| bc_div | output | 3 | latched clock division ratio |
| bc_cur | output | 5 | latched output-current code |
| mon_cfg | output | 8 | latched monitor control, upper nibble zero |

## Verification
The bench first checks that bits shifted while the enable is high are dropped, so a latch pulse afterwards must return the earlier contents rather than the new byte. It checks the lockout: a brightness load during active outputs must leave the old value, while a monitor load in the same state still lands. It checks narrow gray mode after a wide load, where a design that tapped the wrong bit or failed to mask would show stale upper data or a wrong cascade bit. It also covers select code 11, strap forcing while locked, and transparency, where a latch that loads only on an edge would not follow a shift made with `latch_en` held high.

// File: rtl/sdrv_pkg.sv
// Package: shared select encoding and default sizes for the serial
// configuration loader. Assumes a 2-bit select bus.
package sdrv_pkg;
    typedef enum logic [1:0] {
        SEL_GRAY   = 2'b00,
        SEL_BRIGHT = 2'b01,
        SEL_MON    = 2'b10,
        SEL_NONE   = 2'b11
    } reg_sel_e;

    localparam int GS_LONG_D  = 128;
    localparam int GS_SHORT_D = 64;
    localparam int CFG_W_D    = 8;
    localparam int DIV_W_D    = 3;
    localparam int CUR_W_D    = 5;
    localparam int MON_W_D    = 4;
endpackage

// File: rtl/sdrv_sclk_edge.sv
// Module: detects a rising edge of the serial clock in the clk domain.
// Assumes sclk is already synchronous to clk and stays at each level for
// at least one clk cycle. The sampler resets high, so a serial clock that
// is high when reset is released does not count as an edge.
module sdrv_sclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    output logic rise_o
);
    logic sclk_q;

    // Purpose: keep last cycle's serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b1;
        else        sclk_q <= sclk_i;
    end

    assign rise_o = sclk_i & ~sclk_q;

    // R1: a single serial edge produces exactly one shift strobe
    p_single_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/sdrv_shreg.sv
// Module: generic serial-in shift register, shifting toward the MSB.
// Assumes the caller qualifies shift_i with edge, enable and select.
module sdrv_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_i,
    input  logic         sin_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q;

    // Purpose: clear on reset, else move one place and take the new bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (shift_i) q <= {q[W-2:0], sin_i};
    end

    assign q_o = q;

    // R1: a strobe moves the contents up and loads sin into bit 0
    p_shift_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |=> (q_o[0] == $past(sin_i)) && (q_o[W-1:1] == $past(q_o[W-2:0])));

    // R2: no strobe, no change
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_i |=> $stable(q_o));
endmodule

// File: rtl/sdrv_holdlat.sv
// Module: holding latch modelled as a clk-domain register. It copies d_i on
// every cycle that load_i is high and lock_i is low, which gives transparent
// behaviour with one cycle of delay. An active-low strap forces DFLT and
// takes priority over both load and lock. Reset also gives DFLT.
module sdrv_holdlat #(
    parameter int           W    = 8,
    parameter logic [W-1:0] DFLT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         lock_i,
    input  logic         use_cfg_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q;

    // Purpose: default on reset or strap, else follow d_i while loading.
    always_ff @(posedge clk) begin
        if (!rst_n)                 q <= DFLT;
        else if (!use_cfg_i)        q <= DFLT;
        else if (load_i && !lock_i) q <= d_i;
    end

    assign q_o = q;

    // R8 / R9: strap low forces the default value
    p_force_default_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !use_cfg_i |=> q_o == DFLT);

    // R5: an unlocked load copies the input
    p_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (use_cfg_i && load_i && !lock_i) |=> q_o == $past(d_i));

    // R5: no load, no change
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (use_cfg_i && !load_i) |=> $stable(q_o));

    // R10: a locked latch ignores loads
    p_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (use_cfg_i && lock_i) |=> $stable(q_o));
endmodule

// File: rtl/sdrv_serial_cfg.sv
// Module: top of the serial configuration loader. It selects one of three
// shift/latch pairs with reg_sel, qualifies serial shifts with the enable
// and the serial clock edge, and drives the cascade output from the
// selected MSB. It masks narrow gray loads and applies the brightness lock
// and the strap defaults. Assumes all inputs are synchronous to clk.
module sdrv_serial_cfg
    import sdrv_pkg::*;
#(
    parameter int GS_LONG  = GS_LONG_D,
    parameter int GS_SHORT = GS_SHORT_D,
    parameter int CFG_W    = CFG_W_D,
    parameter int DIV_W    = DIV_W_D,
    parameter int CUR_W    = CUR_W_D,
    parameter int MON_W    = MON_W_D
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk,
    input  logic                sin,
    input  logic                shift_en_n,
    input  logic [1:0]          reg_sel,
    input  logic                gs_wide,
    input  logic                latch_en,
    input  logic                bc_cfg_en,
    input  logic                mon_cfg_en,
    input  logic                outputs_off,
    output logic                sout,
    output logic [GS_LONG-1:0]  gs_data,
    output logic [DIV_W-1:0]    bc_div,
    output logic [CUR_W-1:0]    bc_cur,
    output logic [CFG_W-1:0]    mon_cfg
);
    localparam logic [CFG_W-1:0] BC_DFLT  = CFG_W'((1 << CUR_W) - 1);
    localparam logic [CFG_W-1:0] MON_DFLT = CFG_W'(1);
    localparam logic [CFG_W-1:0] MON_MASK = CFG_W'((1 << MON_W) - 1);

    reg_sel_e           sel_e;
    logic               sclk_rise;
    logic               shift_ok;
    logic               gs_shift, bc_shift, mon_shift;
    logic               gs_load, bc_load, mon_load;
    logic [GS_LONG-1:0] gs_sr, gs_d;
    logic [CFG_W-1:0]   bc_sr, bc_q;
    logic [CFG_W-1:0]   mon_sr, mon_d;

    assign sel_e = reg_sel_e'(reg_sel);

    sdrv_sclk_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_i (sclk),
        .rise_o (sclk_rise)
    );

    assign shift_ok = sclk_rise & ~shift_en_n;

    // Purpose: decode the select into per-pair shift and load strobes.
    always_comb begin
        gs_shift  = 1'b0;
        bc_shift  = 1'b0;
        mon_shift = 1'b0;
        gs_load   = 1'b0;
        bc_load   = 1'b0;
        mon_load  = 1'b0;
        case (sel_e)
            SEL_GRAY:   begin gs_shift  = shift_ok; gs_load  = latch_en; end
            SEL_BRIGHT: begin bc_shift  = shift_ok; bc_load  = latch_en; end
            SEL_MON:    begin mon_shift = shift_ok; mon_load = latch_en; end
            default:    ;
        endcase
    end

    sdrv_shreg #(.W(GS_LONG)) u_gs_sr (
        .clk (clk), .rst_n (rst_n), .shift_i (gs_shift), .sin_i (sin), .q_o (gs_sr)
    );
    sdrv_shreg #(.W(CFG_W)) u_bc_sr (
        .clk (clk), .rst_n (rst_n), .shift_i (bc_shift), .sin_i (sin), .q_o (bc_sr)
    );
    sdrv_shreg #(.W(CFG_W)) u_mon_sr (
        .clk (clk), .rst_n (rst_n), .shift_i (mon_shift), .sin_i (sin), .q_o (mon_sr)
    );

    // Purpose: narrow mode keeps only the short window of the gray register.
    always_comb begin
        if (gs_wide) gs_d = gs_sr;
        else         gs_d = GS_LONG'(gs_sr[GS_SHORT-1:0]);
    end

    assign mon_d = mon_sr & MON_MASK;

    sdrv_holdlat #(.W(GS_LONG), .DFLT('0)) u_gs_lat (
        .clk (clk), .rst_n (rst_n), .load_i (gs_load), .lock_i (1'b0),
        .use_cfg_i (1'b1), .d_i (gs_d), .q_o (gs_data)
    );
    sdrv_holdlat #(.W(CFG_W), .DFLT(BC_DFLT)) u_bc_lat (
        .clk (clk), .rst_n (rst_n), .load_i (bc_load), .lock_i (~outputs_off),
        .use_cfg_i (bc_cfg_en), .d_i (bc_sr), .q_o (bc_q)
    );
    sdrv_holdlat #(.W(CFG_W), .DFLT(MON_DFLT)) u_mon_lat (
        .clk (clk), .rst_n (rst_n), .load_i (mon_load), .lock_i (1'b0),
        .use_cfg_i (mon_cfg_en), .d_i (mon_d), .q_o (mon_cfg)
    );

    assign bc_div = bc_q[CFG_W-1 -: DIV_W];
    assign bc_cur = bc_q[CUR_W-1:0];

    // Purpose: cascade output taps the MSB of the active register.
    always_comb begin
        case (sel_e)
            SEL_GRAY:   sout = gs_wide ? gs_sr[GS_LONG-1] : gs_sr[GS_SHORT-1];
            SEL_BRIGHT: sout = bc_sr[CFG_W-1];
            SEL_MON:    sout = mon_sr[CFG_W-1];
            default:    sout = 1'b0;
        endcase
    end

    // R6: the unused code leaves every latch untouched
    p_sel_none_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'b11 && bc_cfg_en && mon_cfg_en) |=>
            ($stable(gs_data) && $stable(bc_div) && $stable(bc_cur) && $stable(mon_cfg)));

    // R10: outputs on and no strap, so the brightness fields stay put
    p_bc_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!outputs_off && bc_cfg_en) |=> ($stable(bc_div) && $stable(bc_cur)));

    // R12: a narrow gray load leaves the upper half at zero
    p_gs_upper_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en && reg_sel == 2'b00 && !gs_wide) |=> gs_data[GS_LONG-1:GS_SHORT] == '0);

    // R9: the monitor latch never carries bits above its control field
    p_mon_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mon_cfg & ~MON_MASK) == '0);
endmodule

// File: tb/sim_sdrv_serial_cfg.sv
`timescale 1ns/1ps
module sim_sdrv_serial_cfg;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk = 1'b0, sin = 1'b0, shift_en_n = 1'b1;
    logic [1:0]   reg_sel = 2'b00;
    logic         gs_wide = 1'b1, latch_en = 1'b0;
    logic         bc_cfg_en = 1'b1, mon_cfg_en = 1'b1, outputs_off = 1'b1;
    logic         sout;
    logic [127:0] gs_data;
    logic [2:0]   bc_div;
    logic [4:0]   bc_cur;
    logic [7:0]   mon_cfg;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sdrv_serial_cfg u0 (
        .clk (clk), .rst_n (rst_n), .sclk (sclk), .sin (sin),
        .shift_en_n (shift_en_n), .reg_sel (reg_sel), .gs_wide (gs_wide),
        .latch_en (latch_en), .bc_cfg_en (bc_cfg_en), .mon_cfg_en (mon_cfg_en),
        .outputs_off (outputs_off), .sout (sout), .gs_data (gs_data),
        .bc_div (bc_div), .bc_cur (bc_cur), .mon_cfg (mon_cfg)
    );

    // stimulus table: {sel[1:0], byte[7:0], outputs_off, exp_bc[7:0], exp_mon[3:0]}
    localparam logic [22:0] VEC [6] = '{
        {2'b01, 8'hA5, 1'b1, 8'hA5, 4'h1},   // R1 load brightness
        {2'b10, 8'h3C, 1'b1, 8'hA5, 4'hC},   // R1 / R9 monitor keeps low nibble
        {2'b01, 8'h5A, 1'b0, 8'hA5, 4'hC},   // R10 brightness locked
        {2'b11, 8'hFF, 1'b1, 8'hA5, 4'hC},   // R6 no target
        {2'b10, 8'h07, 1'b0, 8'hA5, 4'h7},   // R10 monitor still loads
        {2'b01, 8'hE0, 1'b1, 8'hE0, 4'h7}    // R7 div=7 cur=0
    };

    function automatic string vec_tag(int i);
        case (i)
            0: return "R1";
            1: return "R9";
            2: return "R10";
            3: return "R6";
            4: return "R10";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic shift_bit(logic b);
        sin = b; sclk = 1'b1;
        @(negedge clk);
        sclk = 1'b0;
        @(negedge clk);
    endtask

    task automatic shift_byte(logic [7:0] d);
        for (int i = 7; i >= 0; i--) shift_bit(d[i]);
    endtask

    task automatic latch_pulse();
        latch_en = 1'b1;
        @(negedge clk);
        latch_en = 1'b0;
        @(negedge clk);
    endtask

    localparam logic [127:0] P128 = 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F;
    localparam logic [63:0]  C64  = 64'hFEDC_BA98_7654_3210;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 gs_data", gs_data, 128'h0);
        chk("R11 bc", {120'h0, bc_div, bc_cur}, 128'h1F);
        chk("R11 mon", {120'h0, mon_cfg}, 128'h01);
        chk("R11 sout", {127'h0, sout}, 128'h0);

        // table walk
        for (int v = 0; v < 6; v++) begin
            reg_sel = VEC[v][22:21];
            outputs_off = VEC[v][12];
            shift_en_n = 1'b0;
            shift_byte(VEC[v][20:13]);
            latch_pulse();
            chk({vec_tag(v), " bc"}, {120'h0, bc_div, bc_cur}, {120'h0, VEC[v][11:4]});
            chk({vec_tag(v), " mon"}, {120'h0, mon_cfg}, {124'h0, VEC[v][3:0]});
        end
        outputs_off = 1'b1;

        // R4 serial output per select (bc sr = E0, mon sr = 07)
        reg_sel = 2'b01; @(negedge clk);
        chk("R4 sout bc", {127'h0, sout}, 128'h1);
        reg_sel = 2'b10; @(negedge clk);
        chk("R4 sout mon", {127'h0, sout}, 128'h0);
        reg_sel = 2'b11; @(negedge clk);
        chk("R4 sout none", {127'h0, sout}, 128'h0);
        reg_sel = 2'b01;
        shift_bit(1'b0); shift_bit(1'b0);
        chk("R4 sout after 2", {127'h0, sout}, 128'h1);
        shift_bit(1'b0);
        chk("R4 sout after 3", {127'h0, sout}, 128'h0);
        // R5 latch held while latch_en low
        chk("R5 hold", {120'h0, bc_div, bc_cur}, 128'hE0);

        // R2 enable high: shifts dropped, latch returns old contents (00)
        shift_byte(8'h00);
        shift_en_n = 1'b1;
        shift_byte(8'hFF);
        chk("R2 sout", {127'h0, sout}, 128'h0);
        latch_pulse();
        chk("R2 bc", {120'h0, bc_div, bc_cur}, 128'h00);

        // R5 transparent: latch_en high during shifting
        shift_en_n = 1'b0;
        latch_en = 1'b1;
        shift_byte(8'h81);
        chk("R5 transparent", {120'h0, bc_div, bc_cur}, 128'h81);
        latch_en = 1'b0;
        @(negedge clk);

        // R8 strap forces default even while locked
        outputs_off = 1'b0;
        bc_cfg_en = 1'b0; @(negedge clk);
        chk("R8 strap", {120'h0, bc_div, bc_cur}, 128'h1F);
        bc_cfg_en = 1'b1; @(negedge clk);
        outputs_off = 1'b1;

        // R9 monitor strap
        mon_cfg_en = 1'b0; @(negedge clk);
        chk("R9 strap", {120'h0, mon_cfg}, 128'h01);
        mon_cfg_en = 1'b1; @(negedge clk);

        // R3 wide gray register
        reg_sel = 2'b00; gs_wide = 1'b1;
        for (int i = 127; i >= 0; i--) shift_bit(P128[i]);
        chk("R3 sout wide", {127'h0, sout}, {127'h0, P128[127]});
        latch_pulse();
        chk("R3 gs wide", gs_data, P128);

        // R12 narrow gray register after a wide load
        gs_wide = 1'b0;
        for (int i = 63; i >= 0; i--) shift_bit(C64[i]);
        chk("R3 sout narrow", {127'h0, sout}, {127'h0, C64[63]});
        latch_pulse();
        chk("R12 gs narrow", gs_data, {64'h0, C64});

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule